// File: doc/BRIEF.md
# Multi-Format YUV Output Port Scheduler

This block takes one luma sample and two chroma samples (U and V) on every clock and lays them out onto three 8-bit output ports in one of eight sampling formats. Each port comes with a per-bit output-enable vector. The pads or the next stage use that vector to float the bits that a format leaves unused. The formats differ in two ways. The first is whether luma appears on every sample or on every other sample. The second is how much chroma survives and how it is placed: full bytes on two ports, U and V alternating on one port, two-bit slices carried on the upper half of one port, or a four-phase interleave of chroma and luma on the third port.

Samples are collected in groups of eight. An 8-phase counter numbers the samples inside a group. The counter restarts at the clock edge where the sync input is first seen high, and otherwise runs freely modulo eight. Once a group is complete it moves into a holding bank. During the following group the ports present the holding bank, one output element per phase, so each element appears one group after its sample arrived. The upstream averaging and the choice between binary and two's-complement number coding sit outside this block.

Top module: `yuv_port_mux`

## Requirements
- R1: While reset is active, all three ports and all three enable vectors are zero, and the phase counter starts at zero.
- R2: Port A is fully enabled. For format codes 0 to 3 it shows luma sample Y[p] at phase p. For codes 4 to 7 it shows Y[p with bit 0 cleared], so each even-index luma is held for two cycles.
- R3: Codes 0 (8:8:8) and 4 (4:8:8): port B shows U[p] and port C shows V[p], and both ports are fully enabled.
- R4: Code 1 (8:4:4): port B runs U0,V0,U2,V2,U4,V4,U6,V6, and port C is fully disabled.
- R5: Code 5 (4:4:4): port B shows U[p with bit 0 cleared] and port C shows V[p with bit 0 cleared].
- R6: Code 2 (8:2:2): port B bits 7..6 carry a two-bit slice of U and bits 5..4 the same slice of V. The slices go from most significant first (7:6, 5:4, 3:2, 1:0) over four cycles, using sample 0 for phases 0 to 3 and sample 4 for phases 4 to 7. Port B bits 3..0 and all of port C are disabled.
- R7: Codes 3 (8:1:1) and 7 (4:1:1): the same slice layout as R6, but each slice is held for two cycles, so sample 0 spans the whole group.
- R8: Code 6 (4:2:2): port B shows U0,U0,V0,V0,U4,U4,V4,V4 and port C shows U0,Y0,V0,Y2,U4,Y4,V4,Y6, and both ports are fully enabled.
- R9: A sampled rising level on sync makes the sample at that edge number 0 of a new group. Holding sync high does not restart the group again, and without a rising level the phase advances by one modulo 8.
- R10: The output element for phase p is registered at the edge whose sample has phase p, and it is taken from the group that completed at the most recent phase-7 edge.
- R11: Every port bit whose enable is low is driven to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_sel | input | 3 | Output format code (0..7, see R2 to R8) |
| sync_in | input | 1 | Group alignment; its first sampled high level starts a group |
| y_in | input | 8 | Luma sample |
| u_in | input | 8 | Chroma U sample |
| v_in | input | 8 | Chroma V sample |
| port_a | output | 8 | Output port A data |
| port_b | output | 8 | Output port B data |
| port_c | output | 8 | Output port C data |
| oe_a | output | 8 | Per-bit drive enable for port A |
| oe_b | output | 8 | Per-bit drive enable for port B |
| oe_c | output | 8 | Per-bit drive enable for port C |

## Verification
A phase counter that is off by even one position shows up as a rotated schedule. This is visible within one group in the 4:2:2 interleave on port C and in the slice order on port B, where every phase carries a different element. A bank that is copied at the wrong phase mixes samples from two groups in the very next group of outputs. A wrong enable vector or a stale value on a disabled bit shows on the first cycle of the affected format. The bench sweeps all eight codes over whole groups, plus a resynchronisation in the middle of a group, and compares every port and enable on every cycle against an arithmetic model.

// File: rtl/ymx_pkg.sv
package ymx_pkg;
    localparam int PW    = 3;
    localparam int GROUP = 1 << PW;

    typedef enum logic [PW-1:0] {
        FMT_888 = 3'd0,
        FMT_844 = 3'd1,
        FMT_822 = 3'd2,
        FMT_811 = 3'd3,
        FMT_488 = 3'd4,
        FMT_444 = 3'd5,
        FMT_422 = 3'd6,
        FMT_411 = 3'd7
    } fmt_e;
endpackage

// File: rtl/ymx_phase.sv
module ymx_phase
    import ymx_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_in,
    output logic [PW-1:0] ph
);
    typedef struct packed {
        logic          sync;
        logic [PW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic rise;

    always_comb begin
        rise      = sync_in & ~st_q.sync;
        ph        = rise ? '0 : st_q.cnt;
        st_d.sync = sync_in;
        st_d.cnt  = PW'(ph + 1'b1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9: a rising sync restarts the group, so the following phase is 1
    a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_in && !st_q.sync) |=> (st_q.cnt == PW'(1)));
    // R9: without a rising sync the counter advances modulo 8
    a_r9_freerun: assert property (@(posedge clk) disable iff (!rst_n)
        !(sync_in && !st_q.sync) |=> (st_q.cnt == PW'($past(st_q.cnt) + 1'b1)));
endmodule

// File: rtl/ymx_capture.sv
module ymx_capture
    import ymx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [PW-1:0]              ph,
    input  logic [DW-1:0]              y_in,
    input  logic [DW-1:0]              u_in,
    input  logic [DW-1:0]              v_in,
    output logic [GROUP-1:0][DW-1:0]   hold_y,
    output logic [GROUP-1:0][DW-1:0]   hold_u,
    output logic [GROUP-1:0][DW-1:0]   hold_v
);
    typedef struct packed {
        logic [GROUP-1:0][DW-1:0] cy;
        logic [GROUP-1:0][DW-1:0] cu;
        logic [GROUP-1:0][DW-1:0] cv;
        logic [GROUP-1:0][DW-1:0] hy;
        logic [GROUP-1:0][DW-1:0] hu;
        logic [GROUP-1:0][DW-1:0] hv;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.cy[ph] = y_in;
        st_d.cu[ph] = u_in;
        st_d.cv[ph] = v_in;
        if (ph == PW'(GROUP-1)) begin
            st_d.hy = st_d.cy;
            st_d.hu = st_d.cu;
            st_d.hv = st_d.cv;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hold_y = st_q.hy;
    assign hold_u = st_q.hu;
    assign hold_v = st_q.hv;

    // R10: the bank is refreshed at the last phase, with the final sample in place
    a_r10_bank_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PW'(GROUP-1)) |=> (hold_y[GROUP-1] == $past(y_in)));
    // R10: the bank stays stable at every other phase
    a_r10_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ph != PW'(GROUP-1)) |=> ($stable(hold_u) && $stable(hold_v)));
endmodule

// File: rtl/ymx_sched.sv
module ymx_sched
    import ymx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [PW-1:0]              fmt_sel,
    input  logic [PW-1:0]              ph,
    input  logic [GROUP-1:0][DW-1:0]   hold_y,
    input  logic [GROUP-1:0][DW-1:0]   hold_u,
    input  logic [GROUP-1:0][DW-1:0]   hold_v,
    output logic [DW-1:0]              port_a,
    output logic [DW-1:0]              port_b,
    output logic [DW-1:0]              port_c,
    output logic [DW-1:0]              oe_a,
    output logic [DW-1:0]              oe_b,
    output logic [DW-1:0]              oe_c
);
    localparam int QW   = DW / 4;
    localparam int HALF = DW / 2;

    typedef struct packed {
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic [DW-1:0] c;
        logic [DW-1:0] ea;
        logic [DW-1:0] eb;
        logic [DW-1:0] ec;
    } out_t;

    out_t o_d, o_q;
    fmt_e fmt;
    logic [PW-1:0] pe;
    logic [PW-1:0] sidx;
    logic [1:0]    step;
    logic [QW-1:0] u_sl, v_sl;

    always_comb begin
        fmt  = fmt_e'(fmt_sel);
        pe   = {ph[PW-1:1], 1'b0};
        sidx = '0;
        step = ph[1:0];
        if (fmt == FMT_822) begin
            sidx = {ph[2], 2'b00};
            step = ph[1:0];
        end else begin
            sidx = '0;
            step = ph[2:1];
        end
        u_sl = QW'(hold_u[sidx] >> (DW - QW - QW * int'(step)));
        v_sl = QW'(hold_v[sidx] >> (DW - QW - QW * int'(step)));

        o_d    = '0;
        o_d.ea = '1;
        o_d.a  = fmt_sel[2] ? hold_y[pe] : hold_y[ph];
        unique case (fmt)
            FMT_888, FMT_488: begin
                o_d.b  = hold_u[ph];
                o_d.c  = hold_v[ph];
                o_d.eb = '1;
                o_d.ec = '1;
            end
            FMT_844: begin
                o_d.b  = ph[0] ? hold_v[pe] : hold_u[pe];
                o_d.eb = '1;
            end
            FMT_444: begin
                o_d.b  = hold_u[pe];
                o_d.c  = hold_v[pe];
                o_d.eb = '1;
                o_d.ec = '1;
            end
            FMT_822, FMT_811, FMT_411: begin
                o_d.b  = {u_sl, v_sl, {HALF{1'b0}}};
                o_d.eb = {{HALF{1'b1}}, {HALF{1'b0}}};
            end
            FMT_422: begin
                o_d.b  = ph[1] ? hold_v[{ph[2], 2'b00}] : hold_u[{ph[2], 2'b00}];
                o_d.c  = ph[0] ? hold_y[pe]
                       : (ph[1] ? hold_v[{ph[2], 2'b00}] : hold_u[{ph[2], 2'b00}]);
                o_d.eb = '1;
                o_d.ec = '1;
            end
            default: o_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign port_a = o_q.a;
    assign port_b = o_q.b;
    assign port_c = o_q.c;
    assign oe_a   = o_q.ea;
    assign oe_b   = o_q.eb;
    assign oe_c   = o_q.ec;

    // R2: port A is always fully driven once out of reset
    a_r2_port_a_on: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (oe_a == '1));
    // R4: port C floats in 8:4:4
    a_r4_c_off: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_sel == 3'd1) |=> (oe_c == '0));
    // R6 / R7: the slice formats drive only the upper half of port B
    a_r6_low_half_off: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_sel == 3'd2 || fmt_sel == 3'd3 || fmt_sel == 3'd7)
        |=> (oe_b == {{HALF{1'b1}}, {HALF{1'b0}}} && oe_c == '0));
    // R11: undriven bits carry zero on every port
    a_r11_off_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((port_b & ~oe_b) == '0) && ((port_c & ~oe_c) == '0));
endmodule

// File: rtl/yuv_port_mux.sv
module yuv_port_mux
    import ymx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    fmt_sel,
    input  logic          sync_in,
    input  logic [DW-1:0] y_in,
    input  logic [DW-1:0] u_in,
    input  logic [DW-1:0] v_in,
    output logic [DW-1:0] port_a,
    output logic [DW-1:0] port_b,
    output logic [DW-1:0] port_c,
    output logic [DW-1:0] oe_a,
    output logic [DW-1:0] oe_b,
    output logic [DW-1:0] oe_c
);
    logic [PW-1:0]            ph;
    logic [GROUP-1:0][DW-1:0] hy, hu, hv;

    ymx_phase u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_in (sync_in),
        .ph      (ph)
    );

    ymx_capture #(.DW(DW)) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .ph     (ph),
        .y_in   (y_in),
        .u_in   (u_in),
        .v_in   (v_in),
        .hold_y (hy),
        .hold_u (hu),
        .hold_v (hv)
    );

    ymx_sched #(.DW(DW)) u_sched (
        .clk     (clk),
        .rst_n   (rst_n),
        .fmt_sel (fmt_sel),
        .ph      (ph),
        .hold_y  (hy),
        .hold_u  (hu),
        .hold_v  (hv),
        .port_a  (port_a),
        .port_b  (port_b),
        .port_c  (port_c),
        .oe_a    (oe_a),
        .oe_b    (oe_b),
        .oe_c    (oe_c)
    );
endmodule

// File: tb/tb_yuv_port_mux.sv
module tb_yuv_port_mux;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] fmt_sel = 3'd0;
    logic       sync_in = 1'b0;
    logic [7:0] y_in = '0, u_in = '0, v_in = '0;
    logic [7:0] port_a, port_b, port_c, oe_a, oe_b, oe_c;

    int n_cmp = 0;
    int n_bad = 0;
    int t = 0;

    logic [7:0] cy[8], cu[8], cv[8], hy[8], hu[8], hv[8];
    int  nextph = 0;
    bit  prev_sync = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    yuv_port_mux dut (
        .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .sync_in(sync_in),
        .y_in(y_in), .u_in(u_in), .v_in(v_in),
        .port_a(port_a), .port_b(port_b), .port_c(port_c),
        .oe_a(oe_a), .oe_b(oe_b), .oe_c(oe_c)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h (oe,data) t=%0d", req, act, exp, t);
        end
    endtask

    // Expected {enable, data} for a port at phase p, from the requirement text
    function automatic logic [15:0] expect_port(int f, int p, int port);
        int e  = p & 6;
        int s4 = p & 4;
        int s, k;
        logic [7:0] nib;
        if (port == 0) return {8'hFF, (f >= 4) ? hy[e] : hy[p]};     // R2
        case (f)
            0, 4: return (port == 1) ? {8'hFF, hu[p]} : {8'hFF, hv[p]}; // R3
            1:    return (port == 1) ? {8'hFF, (p % 2 == 1) ? hv[e] : hu[e]} : 16'h0; // R4
            5:    return (port == 1) ? {8'hFF, hu[e]} : {8'hFF, hv[e]};  // R5
            6: begin                                                     // R8
                if (port == 1) return {8'hFF, (p % 4 < 2) ? hu[s4] : hv[s4]};
                if (p % 2 == 1) return {8'hFF, hy[p - 1]};
                return {8'hFF, (p % 4 == 0) ? hu[s4] : hv[s4]};
            end
            default: begin                                               // R6, R7
                if (f == 2) begin s = s4; k = p % 4; end
                else        begin s = 0;  k = p / 2; end
                nib = {2'((hu[s] >> (6 - 2*k)) & 3), 2'((hv[s] >> (6 - 2*k)) & 3), 4'h0};
                return (port == 1) ? {8'hF0, nib} : 16'h0;
            end
        endcase
    endfunction

    function automatic string tag(int f, int port, string extra);
        string r;
        if (port == 0) r = "R2 R10";
        else case (f)
            0, 4: r = "R3";
            1:    r = "R4 R11";
            5:    r = "R5";
            2:    r = "R6 R11";
            6:    r = "R8";
            default: r = "R7 R11";
        endcase
        return {r, extra};
    endfunction

    task automatic step(input bit s, input string extra);
        int bph;
        logic [15:0] ea, eb, ec;
        @(negedge clk);
        t++;
        sync_in = s;
        y_in = 8'(8'h10 + t * 37);
        u_in = 8'(t * 53 + 7);
        v_in = ~8'(t * 29);
        bph = (s && !prev_sync) ? 0 : nextph;   // R9 phase model
        prev_sync = s;
        nextph = (bph + 1) % 8;
        ea = expect_port(int'(fmt_sel), bph, 0);
        eb = expect_port(int'(fmt_sel), bph, 1);
        ec = expect_port(int'(fmt_sel), bph, 2);
        cy[bph] = y_in; cu[bph] = u_in; cv[bph] = v_in;
        if (bph == 7) begin
            for (int i = 0; i < 8; i++) begin
                hy[i] = cy[i]; hu[i] = cu[i]; hv[i] = cv[i];
            end
        end
        @(posedge clk);
        #1;
        check(tag(int'(fmt_sel), 0, extra), {oe_a, port_a}, ea);
        check(tag(int'(fmt_sel), 1, extra), {oe_b, port_b}, eb);
        check(tag(int'(fmt_sel), 2, extra), {oe_c, port_c}, ec);
    endtask

    initial begin
        #(PERIOD * 200000);
        n_bad++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            cy[i] = '0; cu[i] = '0; cv[i] = '0; hy[i] = '0; hu[i] = '0; hv[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state on all ports and enables
        check("R1", {oe_a, port_a}, 16'h0);
        check("R1", {oe_b, port_b}, 16'h0);
        check("R1", {oe_c, port_c}, 16'h0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: phase starts at zero, so the model runs from the first edge
        step(1'b0, " R1");
        step(1'b0, " R1");
        // R9: sync held high for several cycles restarts the group only once
        step(1'b1, " R9");
        step(1'b1, " R9");
        step(1'b1, " R9");
        for (int f = 0; f < 8; f++) begin
            fmt_sel = 3'(f);
            for (int c = 0; c < 24; c++) step(1'b0, "");
        end
        // R9: resynchronise in the middle of a group under 4:2:2 and a slice format
        fmt_sel = 3'd6;
        step(1'b0, " R9");
        step(1'b0, " R9");
        step(1'b0, " R9");
        step(1'b1, " R9");
        for (int c = 0; c < 20; c++) step(1'b0, " R9");
        fmt_sel = 3'd7;
        step(1'b1, " R9");
        for (int c = 0; c < 19; c++) step(1'b0, " R9");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule